// File: doc/BRIEF.md
# Programmable Address Chip-Select Decoder

This block compares the 24-bit address of each external memory cycle against six programmable windows and drives one of six active-low select lines for the duration of that cycle. Along with the select, it hands the bus controller a configuration word. This is the configuration of the window that was hit. When no window is hit, it is the configuration of the highest-numbered channel, so the bus always has a usable setting.

Each window is a base and a mask with an enable bit. An address hits when it agrees with the base on every bit the mask keeps. When windows overlap, the lowest-numbered channel wins. The decision is taken once, on the first clock of an external cycle. It is held in registers until the cycle ends, so the select lines cannot glitch while the address bus or the window registers move.

Software programs the windows through a small write port. The write address picks a channel and a field. Out of reset, only channel 0 is live, and it covers the 256 bytes holding the first instruction fetch.

Top module: `cs_decoder`

## Requirements
- R1: After reset every select output is high and `bus_cfg_o` equals `RST_CFG` (default 8'hA5). Channel 0 is enabled with base 24'hFF2000 and mask 24'hFFFF00, and every other channel is disabled.
- R2: Channel k hits when its enable bit is 1 and `((addr_i ^ base_k) & mask_k) == 0`.
- R3: A select is low only while `ext_valid_i` is high. Decoding happens on the first clock edge at which `ext_valid_i` is high. The outputs show the result from the next cycle on. On the first edge with `ext_valid_i` low, all selects return high.
- R4: When several channels hit, only the lowest-numbered one drives its select low. At most one select is ever low.
- R5: When no channel hits, all selects stay high and `bus_cfg_o` takes channel 5's configuration.
- R6: When channel k wins, `cs_n_o[k]` is low and `bus_cfg_o` equals channel k's configuration.
- R7: While `ext_valid_i` stays high after the first edge, `cs_n_o` and `bus_cfg_o` hold. This is true even if `addr_i` changes or any window register is rewritten.
- R8: A write with `wr_en_i` high stores `wr_data_i` into channel `wr_addr_i[4:2]`. The field is chosen by `wr_addr_i[1:0]`: 0 base, 1 mask, 2 configuration (low 8 bits), 3 enable (bit 0). Channel numbers 6 and 7 are ignored and change no channel.
- R9: A disabled channel never drives its select, even if its base and mask match.
- R10: The first fetch address 24'hFF2080 selects channel 0 straight out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_valid_i | input | 1 | High for the whole of an external memory cycle |
| addr_i | input | 24 | Internal address of the cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Channel in [4:2], field in [1:0] |
| wr_data_i | input | 24 | Write data |
| cs_n_o | output | 6 | Active-low select per channel |
| bus_cfg_o | output | 8 | Bus configuration for the current cycle |

## Verification
The hardest case to reach from the ports is a register write that lands inside an active cycle. In that case the held select must not follow the write, while the very next cycle must. The stimulus opens a cycle on a live window and disables that window one edge into the cycle. It then checks that the select and configuration hold, and afterwards repeats the address to see the miss. Writes aimed at the non-existent channels 6 and 7 are chosen so that a decoder dropping the top channel bit would corrupt channels 2 and 3 visibly.

// File: rtl/csd_pkg.sv
package csd_pkg;

    typedef enum logic [1:0] {
        FLD_BASE = 2'd0,
        FLD_MASK = 2'd1,
        FLD_CFG  = 2'd2,
        FLD_CTRL = 2'd3
    } csd_field_e;

endpackage

// File: rtl/csd_regbank.sv
module csd_regbank
    import csd_pkg::*;
#(
    parameter int          NUM_CH    = 6,
    parameter int          ADDR_W    = 24,
    parameter int          CFG_W     = 8,
    parameter int          CH_W      = 3,
    parameter logic [7:0]  RST_CFG   = 8'hA5,
    parameter logic [23:0] BOOT_BASE = 24'hFF2000,
    parameter logic [23:0] BOOT_MASK = 24'hFFFF00
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en_i,
    input  logic [CH_W-1:0]                    wr_ch_i,
    input  logic [1:0]                         wr_fld_i,
    input  logic [ADDR_W-1:0]                  wr_data_i,
    output logic [NUM_CH-1:0][ADDR_W-1:0]      base_o,
    output logic [NUM_CH-1:0][ADDR_W-1:0]      mask_o,
    output logic [NUM_CH-1:0][CFG_W-1:0]       cfg_o,
    output logic [NUM_CH-1:0]                  en_o
);

    typedef struct packed {
        logic [NUM_CH-1:0][ADDR_W-1:0] base;
        logic [NUM_CH-1:0][ADDR_W-1:0] mask;
        logic [NUM_CH-1:0][CFG_W-1:0]  cfg;
        logic [NUM_CH-1:0]             en;
    } bank_t;

    bank_t bank_d, bank_q, bank_rst;
    logic  ch_ok;

    assign ch_ok = (int'(wr_ch_i) < NUM_CH);

    always_comb begin
        bank_rst = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            bank_rst.cfg[i] = CFG_W'(RST_CFG);
        end
        bank_rst.base[0] = ADDR_W'(BOOT_BASE);
        bank_rst.mask[0] = ADDR_W'(BOOT_MASK);
        bank_rst.en[0]   = 1'b1;
    end

    always_comb begin
        bank_d = bank_q;
        if (wr_en_i && ch_ok) begin
            unique case (csd_field_e'(wr_fld_i))
                FLD_BASE: bank_d.base[wr_ch_i] = wr_data_i;
                FLD_MASK: bank_d.mask[wr_ch_i] = wr_data_i;
                FLD_CFG:  bank_d.cfg[wr_ch_i]  = wr_data_i[CFG_W-1:0];
                FLD_CTRL: bank_d.en[wr_ch_i]   = wr_data_i[0];
                default:  bank_d = bank_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= bank_rst;
        else        bank_q <= bank_d;
    end

    assign base_o = bank_q.base;
    assign mask_o = bank_q.mask;
    assign cfg_o  = bank_q.cfg;
    assign en_o   = bank_q.en;

    generate
        if (NUM_CH < (1 << CH_W)) begin : g_badch
            // R8: writes to channel numbers past the last one leave the bank alone
            p_badch_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en_i && (int'(wr_ch_i) >= NUM_CH)) |=> $stable(bank_q));
        end
    endgenerate

endmodule

// File: rtl/csd_match.sv
module csd_match #(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [NUM_CH-1:0][ADDR_W-1:0]  base_i,
    input  logic [NUM_CH-1:0][ADDR_W-1:0]  mask_i,
    input  logic [NUM_CH-1:0]              en_i,
    output logic [NUM_CH-1:0]              hit_o
);

    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_cmp
            logic [ADDR_W-1:0] diff;
            assign diff     = (addr_i ^ base_i[k]) & mask_i[k];
            assign hit_o[k] = en_i[k] && (diff == '0);
        end
    endgenerate

endmodule

// File: rtl/csd_prio.sv
module csd_prio #(
    parameter int NUM_CH = 6,
    parameter int CFG_W  = 8
) (
    input  logic [NUM_CH-1:0]             hit_i,
    input  logic [NUM_CH-1:0][CFG_W-1:0]  cfg_i,
    output logic [NUM_CH-1:0]             grant_o,
    output logic                          any_o,
    output logic [CFG_W-1:0]              cfg_o
);

    always_comb begin
        grant_o = '0;
        cfg_o   = cfg_i[NUM_CH-1];
        for (int k = NUM_CH - 1; k >= 0; k--) begin
            if (hit_i[k]) begin
                grant_o    = '0;
                grant_o[k] = 1'b1;
                cfg_o      = cfg_i[k];
            end
        end
        any_o = |hit_i;
    end

endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
    import csd_pkg::*;
#(
    parameter int          NUM_CH    = 6,
    parameter int          ADDR_W    = 24,
    parameter int          CFG_W     = 8,
    parameter logic [7:0]  RST_CFG   = 8'hA5,
    parameter logic [23:0] BOOT_BASE = 24'hFF2000,
    parameter logic [23:0] BOOT_MASK = 24'hFFFF00,
    localparam int         CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int         WA_W      = CH_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [WA_W-1:0]   wr_addr_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    output logic [NUM_CH-1:0] cs_n_o,
    output logic [CFG_W-1:0]  bus_cfg_o
);

    typedef struct packed {
        logic              valid;
        logic [NUM_CH-1:0] cs_n;
        logic [CFG_W-1:0]  cfg;
    } out_t;

    logic [NUM_CH-1:0][ADDR_W-1:0] ch_base, ch_mask;
    logic [NUM_CH-1:0][CFG_W-1:0]  ch_cfg;
    logic [NUM_CH-1:0]             ch_en, hit, grant;
    logic                          any_hit, start;
    logic [CFG_W-1:0]              sel_cfg;
    out_t                          st_d, st_q;

    csd_regbank #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CFG_W(CFG_W), .CH_W(CH_W),
        .RST_CFG(RST_CFG), .BOOT_BASE(BOOT_BASE), .BOOT_MASK(BOOT_MASK)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_ch_i(wr_addr_i[WA_W-1:2]),
        .wr_fld_i(wr_addr_i[1:0]), .wr_data_i(wr_data_i),
        .base_o(ch_base), .mask_o(ch_mask), .cfg_o(ch_cfg), .en_o(ch_en)
    );

    csd_match #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_match (
        .addr_i(addr_i), .base_i(ch_base), .mask_i(ch_mask),
        .en_i(ch_en), .hit_o(hit)
    );

    csd_prio #(.NUM_CH(NUM_CH), .CFG_W(CFG_W)) u_prio (
        .hit_i(hit), .cfg_i(ch_cfg), .grant_o(grant),
        .any_o(any_hit), .cfg_o(sel_cfg)
    );

    assign start = ext_valid_i && !st_q.valid;

    always_comb begin
        st_d       = st_q;
        st_d.valid = ext_valid_i;
        if (!ext_valid_i) begin
            st_d.cs_n = '1;
        end else if (start) begin
            st_d.cs_n = ~grant;
            st_d.cfg  = sel_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.valid <= 1'b0;
            st_q.cs_n  <= '1;
            st_q.cfg   <= CFG_W'(RST_CFG);
        end else begin
            st_q <= st_d;
        end
    end

    assign cs_n_o    = st_q.cs_n;
    assign bus_cfg_o = st_q.cfg;

    // R3: outside an external cycle every select is released
    p_idle_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_valid_i |=> (cs_n_o == '1));

    // R4: never more than one select low
    p_single_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));

    // R4/R2: a low select always belongs to a channel that hit at decode time
    p_select_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (((~cs_n_o) & ~$past(hit)) == '0));

    // R5: a miss releases all selects and uses the last channel's setting
    p_fallback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !any_hit) |=>
            ((cs_n_o == '1) && (bus_cfg_o == $past(ch_cfg[NUM_CH-1]))));

    // R7: outputs frozen for the rest of the cycle
    p_hold_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_valid_i && st_q.valid) |=> ($stable(cs_n_o) && $stable(bus_cfg_o)));

    // R9: disabled channels never get a select
    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (((~cs_n_o) & ~$past(ch_en)) == '0));

endmodule

// File: tb/tb_cs_decoder.sv
`timescale 1ns/1ps
module tb_cs_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_valid_i = 1'b0;
    logic [23:0] addr_i = '0;
    logic        wr_en_i = 1'b0;
    logic [4:0]  wr_addr_i = '0;
    logic [23:0] wr_data_i = '0;
    logic [5:0]  cs_n_o;
    logic [7:0]  bus_cfg_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cs_decoder dut (
        .clk(clk), .rst_n(rst_n), .ext_valid_i(ext_valid_i), .addr_i(addr_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .cs_n_o(cs_n_o), .bus_cfg_o(bus_cfg_o)
    );

    // address, expected cs_n, expected cfg
    localparam int NV = 9;
    localparam logic [37:0] VECS [0:NV-1] = '{
        {24'hFF2080, 6'b111110, 8'hA5},
        {24'hFF2100, 6'b111111, 8'h55},
        {24'h120034, 6'b111101, 8'h11},
        {24'h105555, 6'b111101, 8'h11},
        {24'h800FFF, 6'b110111, 8'h33},
        {24'h801000, 6'b111111, 8'h55},
        {24'h900010, 6'b111111, 8'h55},
        {24'hA0ABCD, 6'b011111, 8'h55},
        {24'h000000, 6'b111111, 8'h55}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_reg(int ch, int fld, logic [23:0] data);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_addr_i = {3'(ch), 2'(fld)};
        wr_data_i = data;
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    task automatic bus_cycle(logic [23:0] a, logic [5:0] ecs, logic [7:0] ecfg, string req);
        @(negedge clk);
        ext_valid_i = 1'b1;
        addr_i      = a;
        @(negedge clk);
        check({req, " select"}, 32'(cs_n_o), 32'(ecs));
        check({req, " config"}, 32'(bus_cfg_o), 32'(ecfg));
        addr_i = ~a;
        @(negedge clk);
        check("R7 hold select", 32'(cs_n_o), 32'(ecs));
        check("R7 hold config", 32'(bus_cfg_o), 32'(ecfg));
        ext_valid_i = 1'b0;
        @(negedge clk);
        check("R3 release", 32'(cs_n_o), 32'h3F);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset select", 32'(cs_n_o), 32'h3F);
        check("R1 reset config", 32'(bus_cfg_o), 32'hA5);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 32'(cs_n_o), 32'h3F);

        // R10: first fetch address hits channel 0 straight from reset
        bus_cycle(24'hFF2080, 6'b111110, 8'hA5, "R10 boot fetch");
        bus_cycle(24'hFF20FF, 6'b111110, 8'hA5, "R1 top of boot range");
        bus_cycle(24'hFF2100, 6'b111111, 8'hA5, "R1 outside boot range");
        bus_cycle(24'h000000, 6'b111111, 8'hA5, "R9 others disabled at reset");

        // R8: program windows
        write_reg(1, 0, 24'h100000); write_reg(1, 1, 24'hF00000);
        write_reg(1, 2, 24'h000011); write_reg(1, 3, 24'h000001);
        write_reg(2, 0, 24'h120000); write_reg(2, 1, 24'hFF0000);
        write_reg(2, 2, 24'h000022); write_reg(2, 3, 24'h000001);
        write_reg(3, 0, 24'h800000); write_reg(3, 1, 24'hFFF000);
        write_reg(3, 2, 24'h000033); write_reg(3, 3, 24'h000001);
        write_reg(4, 0, 24'h900000); write_reg(4, 1, 24'hFF0000);
        write_reg(4, 2, 24'h000044);
        write_reg(5, 0, 24'hA00000); write_reg(5, 1, 24'hFF0000);
        write_reg(5, 2, 24'h000055); write_reg(5, 3, 24'h000001);
        // R8: writes to channels 6 and 7 must not alias onto 2 and 3
        write_reg(6, 1, 24'h000000);
        write_reg(7, 2, 24'h000077);

        // R2 R4 R5 R6 R9 table walk
        for (int i = 0; i < NV; i++) begin
            bus_cycle(VECS[i][37:14], VECS[i][13:8], VECS[i][7:0], "R2/R4/R5/R6 table");
        end

        // R4: explicit overlap, channel 1 beats channel 2
        bus_cycle(24'h12FFFF, 6'b111101, 8'h11, "R4 overlap priority");

        // R7: disable channel 3 in the middle of its cycle
        @(negedge clk);
        ext_valid_i = 1'b1;
        addr_i      = 24'h800010;
        @(negedge clk);
        check("R6 pre-write select", 32'(cs_n_o), 32'h37);
        wr_en_i   = 1'b1;
        wr_addr_i = {3'd3, 2'd3};
        wr_data_i = 24'h0;
        @(negedge clk);
        wr_en_i = 1'b0;
        check("R7 write mid-cycle select", 32'(cs_n_o), 32'h37);
        check("R7 write mid-cycle config", 32'(bus_cfg_o), 32'h33);
        @(negedge clk);
        check("R7 still held", 32'(cs_n_o), 32'h37);
        ext_valid_i = 1'b0;
        @(negedge clk);
        check("R3 release after hold", 32'(cs_n_o), 32'h3F);
        bus_cycle(24'h800010, 6'b111111, 8'h55, "R9 disabled after write");

        // R2/R8: move channel 3 and re-enable
        write_reg(3, 0, 24'h300000);
        write_reg(3, 1, 24'hFFFF00);
        write_reg(3, 3, 24'h000001);
        bus_cycle(24'h3000AB, 6'b110111, 8'h33, "R2 reprogrammed range");
        bus_cycle(24'h3001AB, 6'b111111, 8'h55, "R2 just outside new range");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule